// File: doc/BRIEF.md
# Two-Processor Byte Mailbox with Handshake Flags

This block connects a host processor to an I/O controller processor through a pair of single-byte buffers, one for each direction, plus a 4-bit register of handshake flags. The host writes bytes either as plain data or as commands. The flag register records which kind of byte was written. The controller picks the byte up and answers through its own output buffer. Two spare flags let the controller signal its own state back to the host.

Each access is a one-cycle strobe in a single clock domain. Read data is presented continuously from the buffer registers. The read strobe only updates the flags. The controller side sees the world inverted: bytes it reads come back complemented, and bytes it writes are stored complemented. Its status view is also the complement of the host view, with the upper bits forced high.

Top module: `dual_cpu_mailbox`

## Requirements
- R1: After reset, host_status is 4'hF, ctl_status is 8'hF0, host_rdata is 8'h00 and ctl_rdata is 8'hFF.
- R2: A host_wr_data strobe stores host_wdata in the inbound buffer, sets bit 1 (inbound full) and clears bit 3 (F1), all visible one cycle later.
- R3: A host_wr_cmd strobe stores host_wdata, sets bit 1 and sets bit 3. If it coincides with host_wr_data, bit 3 ends up set.
- R4: ctl_rdata always shows the complement of the inbound buffer. A ctl_rd_in strobe clears bit 1 on the next cycle.
- R5: A ctl_wr_out strobe stores the complement of ctl_wdata in the outbound buffer. On the next cycle bit 0 (outbound full) becomes 1 if ctl_addr0 was 0, or 0 if ctl_addr0 was 1.
- R6: host_rdata always shows the outbound buffer unchanged. A host_rd_data strobe clears bit 0 on the next cycle.
- R7: A ctl_wr_f0 strobe loads bit 2 (F0) from ctl_addr0.
- R8: ctl_set_f1 sets bit 3 and ctl_clr_f1 clears it. When both arrive together, bit 3 is set.
- R9: host_status is the raw flag nibble {F1,F0,IBF,OBF}. ctl_status is 4'hF in bits 7:4 and the complemented nibble in bits 3:0.
- R10: When the host and the controller act on the same flag in the same cycle, the host's action wins. This covers a host read against a controller write with ctl_addr0=0, a host write against ctl_rd_in, and a host write against either F1 port.
- R11: A flag or buffer addressed by no strobe in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_data | input | 1 | Host data-port write strobe |
| host_wr_cmd | input | 1 | Host command-port write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd_data | input | 1 | Host data-port read strobe |
| host_rdata | output | 8 | Outbound buffer as seen by host |
| host_status | output | 4 | Flag nibble, host view |
| ctl_wr_out | input | 1 | Controller outbound-buffer write strobe |
| ctl_wr_f0 | input | 1 | Controller F0 write strobe |
| ctl_addr0 | input | 1 | Controller address bit 0 (flag value for out/F0 writes) |
| ctl_wdata | input | 8 | Controller write byte |
| ctl_set_f1 | input | 1 | Controller F1 set strobe |
| ctl_clr_f1 | input | 1 | Controller F1 clear strobe |
| ctl_rd_in | input | 1 | Controller inbound-buffer read strobe |
| ctl_rdata | output | 8 | Inbound buffer, complemented |
| ctl_status | output | 8 | Flag nibble complemented, upper bits high |

## Verification
Every flag change and every buffer load lands on the first clock edge after its strobe. Both read-data outputs and both status outputs are driven directly from registers, so each result is due exactly one cycle after the stimulus. The bench applies strobes just after a falling edge, lets one rising edge pass, and compares all four outputs at the following falling edge against its own model. The strobe sweep covers every combination of the nine control inputs, with the flag state carried over from the previous combination, so conflicting set and clear pairs are met from many starting states.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int FLAG_W = 4;

    // Packed so that obf is bit 0 and f1 is bit 3.
    typedef struct packed {
        logic f1;
        logic f0;
        logic ibf;
        logic obf;
    } mbx_flags_t;

    localparam mbx_flags_t FLAGS_RST = '{f1: 1'b1, f0: 1'b1, ibf: 1'b1, obf: 1'b1};

    typedef struct packed {
        logic wr_data;
        logic wr_cmd;
        logic rd_data;
    } host_req_t;

    typedef struct packed {
        logic wr_out;
        logic addr0;
        logic wr_f0;
        logic set_f1;
        logic clr_f1;
        logic rd_in;
    } ctl_req_t;
endpackage

// File: rtl/mbx_byte_reg.sv
module mbx_byte_reg #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] din_eff;
    logic [W-1:0] data_d, data_q;

    generate
        if (INVERT) begin : g_inv
            assign din_eff = ~din;
        end else begin : g_pass
            assign din_eff = din;
        end
    endgenerate

    always_comb begin
        data_d = data_q;
        if (load) data_d = din_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;

    // Inbound copy serves R2, outbound copy serves R5.
    assert_byte_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dout == (INVERT ? ~$past(din) : $past(din)));

    assert_byte_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/mbx_flag_ctrl.sv
module mbx_flag_ctrl
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  host_req_t  h,
    input  ctl_req_t   c,
    output mbx_flags_t flags
);
    mbx_flags_t flags_d, flags_q;
    logic       host_wr;

    assign host_wr = h.wr_data | h.wr_cmd;

    always_comb begin
        flags_d = flags_q;
        // Controller actions first; host actions below override them.
        if (c.wr_out) flags_d.obf = ~c.addr0;
        if (c.rd_in)  flags_d.ibf = 1'b0;
        if (c.wr_f0)  flags_d.f0  = c.addr0;
        if (c.clr_f1) flags_d.f1  = 1'b0;
        if (c.set_f1) flags_d.f1  = 1'b1;
        if (h.rd_data) flags_d.obf = 1'b0;
        if (host_wr)   flags_d.ibf = 1'b1;
        if (h.wr_data) flags_d.f1  = 1'b0;
        if (h.wr_cmd)  flags_d.f1  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= FLAGS_RST;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    assert_ibf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> flags_q.ibf);

    assert_f1_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h.wr_data && !h.wr_cmd) |=> !flags_q.f1);

    assert_f1_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        h.wr_cmd |=> flags_q.f1);

    assert_ibf_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c.rd_in && !host_wr) |=> !flags_q.ibf);

    assert_obf_ctl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c.wr_out && !h.rd_data) |=> flags_q.obf == !$past(c.addr0));

    assert_obf_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        h.rd_data |=> !flags_q.obf);

    assert_f0_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c.wr_f0 |=> flags_q.f0 == $past(c.addr0));

    assert_f1_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c.set_f1 && !host_wr) |=> flags_q.f1);

    assert_f1_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c.clr_f1 && !c.set_f1 && !host_wr) |=> !flags_q.f1);

    assert_f0_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !c.wr_f0 |=> $stable(flags_q.f0));
endmodule

// File: rtl/dual_cpu_mailbox.sv
module dual_cpu_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_data,
    input  logic              host_wr_cmd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd_data,
    output logic [DATA_W-1:0] host_rdata,
    output logic [FLAG_W-1:0] host_status,
    input  logic              ctl_wr_out,
    input  logic              ctl_wr_f0,
    input  logic              ctl_addr0,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              ctl_set_f1,
    input  logic              ctl_clr_f1,
    input  logic              ctl_rd_in,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic [DATA_W-1:0] ctl_status
);
    localparam int PAD_W = DATA_W - FLAG_W;

    host_req_t          h_req;
    ctl_req_t           c_req;
    mbx_flags_t         flags;
    logic [DATA_W-1:0]  inbound_q;
    logic [DATA_W-1:0]  outbound_q;

    assign h_req = '{wr_data: host_wr_data, wr_cmd: host_wr_cmd, rd_data: host_rd_data};
    assign c_req = '{wr_out: ctl_wr_out, addr0: ctl_addr0, wr_f0: ctl_wr_f0,
                     set_f1: ctl_set_f1, clr_f1: ctl_clr_f1, rd_in: ctl_rd_in};

    mbx_byte_reg #(.W(DATA_W), .INVERT(1'b0)) u_inbound (
        .clk  (clk),
        .rst_n(rst_n),
        .load (host_wr_data | host_wr_cmd),
        .din  (host_wdata),
        .dout (inbound_q)
    );

    mbx_byte_reg #(.W(DATA_W), .INVERT(1'b1)) u_outbound (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ctl_wr_out),
        .din  (ctl_wdata),
        .dout (outbound_q)
    );

    mbx_flag_ctrl u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .h    (h_req),
        .c    (c_req),
        .flags(flags)
    );

    assign host_rdata  = outbound_q;
    assign ctl_rdata   = ~inbound_q;
    assign host_status = flags;
    assign ctl_status  = {{PAD_W{1'b1}}, ~flags};

    assert_ctl_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_data || host_wr_cmd) |=> ctl_rdata == ~$past(host_wdata));

    assert_host_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_out |=> host_rdata == ~$past(ctl_wdata));

    assert_obf_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_data && ctl_wr_out && !ctl_addr0) |=> !host_status[0]);

    assert_ibf_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr_data || host_wr_cmd) && ctl_rd_in) |=> host_status[1]);

    assert_ctl_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_status[FLAG_W-1:0] == ~host_status);
endmodule

// File: tb/dual_cpu_mailbox_tb.sv
module dual_cpu_mailbox_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_data = 1'b0, host_wr_cmd = 1'b0, host_rd_data = 1'b0;
    logic [7:0] host_wdata = 8'h00, ctl_wdata = 8'h00;
    logic       ctl_wr_out = 1'b0, ctl_wr_f0 = 1'b0, ctl_addr0 = 1'b0;
    logic       ctl_set_f1 = 1'b0, ctl_clr_f1 = 1'b0, ctl_rd_in = 1'b0;
    logic [7:0] host_rdata, ctl_rdata, ctl_status;
    logic [3:0] host_status;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [3:0] exp_flags;
    logic [7:0] exp_in, exp_out;

    always #4 clk = ~clk;

    dual_cpu_mailbox dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr_data(host_wr_data), .host_wr_cmd(host_wr_cmd), .host_wdata(host_wdata),
        .host_rd_data(host_rd_data), .host_rdata(host_rdata), .host_status(host_status),
        .ctl_wr_out(ctl_wr_out), .ctl_wr_f0(ctl_wr_f0), .ctl_addr0(ctl_addr0),
        .ctl_wdata(ctl_wdata), .ctl_set_f1(ctl_set_f1), .ctl_clr_f1(ctl_clr_f1),
        .ctl_rd_in(ctl_rd_in), .ctl_rdata(ctl_rdata), .ctl_status(ctl_status)
    );

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "host_rdata",  host_rdata, exp_out);
        cmp(tag, "ctl_rdata",   ctl_rdata, ~exp_in);
        cmp(tag, "host_status", {4'h0, host_status}, {4'h0, exp_flags});
        cmp(tag, "ctl_status",  ctl_status, {4'hF, ~exp_flags});
    endtask

    // v: [0] host data wr, [1] host cmd wr, [2] host rd, [3] ctl out wr,
    //    [4] ctl addr0, [5] ctl F0 wr, [6] ctl F1 set, [7] ctl F1 clr, [8] ctl in rd
    task automatic apply(input logic [8:0] v, input logic [7:0] hd, input logic [7:0] cd, input string tag);
        host_wr_data = v[0]; host_wr_cmd = v[1]; host_rd_data = v[2];
        ctl_wr_out = v[3]; ctl_addr0 = v[4]; ctl_wr_f0 = v[5];
        ctl_set_f1 = v[6]; ctl_clr_f1 = v[7]; ctl_rd_in = v[8];
        host_wdata = hd; ctl_wdata = cd;
        @(posedge clk);
        // Model from the requirements; host actions applied last (R10).
        if (v[3]) begin exp_out = ~cd; exp_flags[0] = ~v[4]; end
        if (v[8]) exp_flags[1] = 1'b0;
        if (v[5]) exp_flags[2] = v[4];
        if (v[7]) exp_flags[3] = 1'b0;
        if (v[6]) exp_flags[3] = 1'b1;
        if (v[2]) exp_flags[0] = 1'b0;
        if (v[0] || v[1]) begin exp_in = hd; exp_flags[1] = 1'b1; end
        if (v[0]) exp_flags[3] = 1'b0;
        if (v[1]) exp_flags[3] = 1'b1;
        @(negedge clk);
        {host_wr_data, host_wr_cmd, host_rd_data, ctl_wr_out, ctl_addr0,
         ctl_wr_f0, ctl_set_f1, ctl_clr_f1, ctl_rd_in} = '0;
        check_all(tag);
    endtask

    initial begin
        exp_flags = 4'hF; exp_in = 8'h00; exp_out = 8'h00;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        apply(9'b0_0000_0001, 8'hA5, 8'h00, "R2 data write");
        apply(9'b1_0000_0000, 8'h00, 8'h00, "R4 ctl read");
        apply(9'b0_0000_0010, 8'h3C, 8'h00, "R3 cmd write");
        apply(9'b0_0000_0011, 8'h96, 8'h00, "R3 cmd with data");
        apply(9'b0_0000_1000, 8'h00, 8'h81, "R5 out write addr0=0");
        apply(9'b0_0000_0100, 8'h00, 8'h00, "R6 host read");
        apply(9'b0_0001_1000, 8'h00, 8'h7E, "R5 out write addr0=1");
        apply(9'b0_0011_0000, 8'h00, 8'h00, "R7 F0 from 1");
        apply(9'b0_0010_0000, 8'h00, 8'h00, "R7 F0 from 0");
        apply(9'b0_1000_0000, 8'h00, 8'h00, "R8 clear F1");
        apply(9'b0_0100_0000, 8'h00, 8'h00, "R8 set F1");
        apply(9'b0_1100_0000, 8'h00, 8'h00, "R8 set and clear");
        apply(9'b0_0000_0000, 8'hFF, 8'hFF, "R11 idle");
        apply(9'b0_0000_1100, 8'h00, 8'h11, "R10 host read vs ctl set");
        apply(9'b1_1000_0001, 8'h5A, 8'h00, "R10 host write vs ctl read");
        apply(9'b0_0100_0001, 8'hC3, 8'h00, "R10 data write vs F1 set");
        apply(9'b0_0011_0000, 8'h00, 8'h00, "R11 F0 only");
        apply(9'b0_0000_0000, 8'h00, 8'h00, "R9 status views");

        for (int v = 0; v < 512; v++) begin
            apply(v[8:0], v[7:0], v[7:0] ^ 8'h5A, "R9/R10 sweep");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule